// File: doc/BRIEF.md
# Clock Reference Qualification Monitor

This block watches a set of clock references and decides, for each one independently, whether it is fit to be used as a timing source. Every reference brings two inputs from logic outside the block: a flag that reports missing activity, and a signed measurement of its frequency offset. The block compares the magnitude of that offset against two programmable limits. The tighter limit is used when a reference is trying to earn qualification. The looser limit is used when a qualified reference is being judged for removal. The gap between the two limits gives hysteresis, so a reference drifting slightly outside the tight limit is not dropped.

A reference earns qualification only after it stays alarm-free and inside the tight limit for a programmable number of consecutive cycles. It loses qualification in the cycle after an activity alarm or an offset beyond the loose limit. The qualified bits of all references are presented together as one status bitmap. Each reference also has an age counter that measures how long it has been continuously qualified. A downstream selector can use that age to break ties between references of equal priority.

Top module: `refqual_monitor`

## Requirements
- R1: After reset every bit of `qual_map_o` is 0 and every age field of `age_o` is 0.
- R2: A reference is in range when its alarm is low and |offset| <= `qual_lim_i`. With D = `dwell_i`, its status bit rises at the clock edge that samples the (D+1)th consecutive in-range cycle, and not earlier.
- R3: Before qualification, any cycle with the alarm high or |offset| > `qual_lim_i` restarts the consecutive-cycle count from zero.
- R4: A qualified reference whose alarm is high at a clock edge is unqualified after that edge.
- R5: A qualified reference whose |offset| exceeds the disqualification limit is unqualified after that edge. An offset between the two limits leaves it qualified.
- R6: The disqualification limit in effect is the larger of `disq_lim_i` and `qual_lim_i`.
- R7: Offsets are two's complement, and the comparisons use their exact magnitude, including 2^(OFS_W-1) for the most negative code.
- R8: A reference's age is 0 in the cycle its status bit rises. It then rises by 1 per cycle while the reference stays qualified and holds at 2^AGE_W-1. It reads 0 whenever the reference is unqualified.
- R9: Reference i uses bit i of `alarm_i` and `qual_map_o`, and bits [i*OFS_W +: OFS_W] of `offset_i` and [i*AGE_W +: AGE_W] of `age_o`.
- R10: After losing qualification, a reference must again serve the full D+1 consecutive in-range cycles before its bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_i | input | N_REFS | Activity alarm per reference |
| offset_i | input | N_REFS*OFS_W | Signed frequency offset per reference |
| qual_lim_i | input | OFS_W | Magnitude limit for gaining qualification |
| disq_lim_i | input | OFS_W | Magnitude limit for losing qualification |
| dwell_i | input | DWELL_W | Qualification time D in cycles |
| qual_map_o | output | N_REFS | Qualified status bitmap |
| age_o | output | N_REFS*AGE_W | Cycles each reference has been qualified |

## Verification
A dwell count left stale after an out-of-range cycle shows at the ports as a status bit that rises before D+1 clean cycles have passed. The error is visible at the first edge where the rise comes early. A wrong window comparison or a wrong magnitude for negative offsets shows as a bit that fails to drop, or drops in the middle band, one edge after the offending offset. A corrupted age counter shows on `age_o` in the very next cycle, because the bench predicts every age value cycle by cycle and also holds one reference long enough to reach saturation.

// File: rtl/refqual_pkg.sv
package refqual_pkg;
  // Result of judging one reference's alarm and offset in one cycle
  typedef struct packed {
    logic in_qual;   // alarm clear and magnitude within qualification limit
    logic drop_req;  // alarm set or magnitude beyond effective removal limit
  } win_res_t;
endpackage

// File: rtl/refqual_window.sv
module refqual_window
  import refqual_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             alarm,
  input  logic [OFS_W-1:0] offset,
  input  logic [OFS_W-1:0] qual_lim,
  input  logic [OFS_W-1:0] disq_lim,
  output win_res_t         res
);
  // Exact magnitude of a two's complement value; fits OFS_W unsigned bits
  function automatic logic [OFS_W-1:0] ofs_mag(input logic [OFS_W-1:0] v);
    return v[OFS_W-1] ? (~v + 1'b1) : v;
  endfunction

  // Removal limit never tighter than the entry limit
  function automatic logic [OFS_W-1:0] eff_limit(input logic [OFS_W-1:0] q,
                                                 input logic [OFS_W-1:0] d);
    return (d < q) ? q : d;
  endfunction

  logic [OFS_W-1:0] mag;
  logic [OFS_W-1:0] disq_eff;

  always_comb begin
    mag          = ofs_mag(offset);
    disq_eff     = eff_limit(qual_lim, disq_lim);
    res.in_qual  = !alarm && (mag <= qual_lim);
    res.drop_req = alarm || (mag > disq_eff);
  end
endmodule

// File: rtl/refqual_chan.sv
module refqual_chan #(
  parameter int DWELL_W = 16,
  parameter int AGE_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_qual,
  input  logic               drop_req,
  input  logic [DWELL_W-1:0] dwell_lim,
  output logic               qual_o,
  output logic [AGE_W-1:0]   age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic               qual_q;
  logic [DWELL_W-1:0] dwell_cnt;
  logic [AGE_W-1:0]   age_q;

  // Named events for the assertions
  logic dwell_met;
  logic qual_gain;
  logic qual_loss;

  assign dwell_met = in_qual && (dwell_cnt >= dwell_lim);
  assign qual_gain = !qual_q && dwell_met;
  assign qual_loss = qual_q && drop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q    <= 1'b0;
      dwell_cnt <= '0;
      age_q     <= '0;
    end else if (!qual_q) begin
      if (!in_qual) begin
        dwell_cnt <= '0;
      end else if (dwell_met) begin
        qual_q    <= 1'b1;
        dwell_cnt <= '0;
        age_q     <= '0;
      end else begin
        dwell_cnt <= dwell_cnt + 1'b1;
      end
    end else if (qual_loss) begin
      qual_q    <= 1'b0;
      dwell_cnt <= '0;
      age_q     <= '0;
    end else if (age_q != AGE_MAX) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign qual_o = qual_q;
  assign age_o  = age_q;

  // R2: a rise always follows a sampled in-range cycle
  p_rise_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> $past(in_qual));
  // R3: an out-of-range cycle while unqualified restarts the count
  p_dwell_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_q && !in_qual) |=> (dwell_cnt == '0 && !qual_q));
  // R4/R5: a removal request clears the status at the next edge
  p_drop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_q && drop_req) |=> !qual_q);
  // R5: no removal request keeps the status
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_q && !drop_req) |=> qual_q);
  // R6: entry window lies inside removal window
  p_window_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_qual |-> !drop_req);
  // R8: age starts at zero and reads zero while unqualified
  p_age_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> (age_q == '0));
  p_age_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_q |-> (age_q == '0));
  p_age_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_q && !drop_req && age_q != AGE_MAX) |=> (age_q == $past(age_q) + 1'b1));
endmodule

// File: rtl/refqual_monitor.sv
module refqual_monitor
  import refqual_pkg::*;
#(
  parameter int N_REFS  = 4,
  parameter int OFS_W   = 16,
  parameter int DWELL_W = 16,
  parameter int AGE_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REFS-1:0]       alarm_i,
  input  logic [N_REFS*OFS_W-1:0] offset_i,
  input  logic [OFS_W-1:0]        qual_lim_i,
  input  logic [OFS_W-1:0]        disq_lim_i,
  input  logic [DWELL_W-1:0]      dwell_i,
  output logic [N_REFS-1:0]       qual_map_o,
  output logic [N_REFS*AGE_W-1:0] age_o
);
  win_res_t win [N_REFS];

  for (genvar i = 0; i < N_REFS; i++) begin : g_ref
    refqual_window #(.OFS_W(OFS_W)) i_win (
      .alarm    (alarm_i[i]),
      .offset   (offset_i[i*OFS_W +: OFS_W]),
      .qual_lim (qual_lim_i),
      .disq_lim (disq_lim_i),
      .res      (win[i])
    );

    refqual_chan #(.DWELL_W(DWELL_W), .AGE_W(AGE_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_qual   (win[i].in_qual),
      .drop_req  (win[i].drop_req),
      .dwell_lim (dwell_i),
      .qual_o    (qual_map_o[i]),
      .age_o     (age_o[i*AGE_W +: AGE_W])
    );

    // R4: an alarm on a qualified reference clears its bit at the next edge
    p_alarm_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_map_o[i] && alarm_i[i]) |=> !qual_map_o[i]);
  end
endmodule

// File: tb/test_refqual_monitor.sv
module test_refqual_monitor;
  localparam int N      = 4;
  localparam int OW     = 16;
  localparam int DW     = 16;
  localparam int AW     = 12;
  localparam int AGEMAX = (1 << AW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    alarm_i;
  logic [N*OW-1:0] offset_i;
  logic [OW-1:0]   qual_lim_i, disq_lim_i;
  logic [DW-1:0]   dwell_i;
  logic [N-1:0]    qual_map_o;
  logic [N*AW-1:0] age_o;

  logic [OW-1:0] ofs [N];
  always_comb for (int i = 0; i < N; i++) offset_i[i*OW +: OW] = ofs[i];

  refqual_monitor #(.N_REFS(N), .OFS_W(OW), .DWELL_W(DW), .AGE_W(AW)) i_refqual_monitor (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .offset_i(offset_i),
    .qual_lim_i(qual_lim_i), .disq_lim_i(disq_lim_i), .dwell_i(dwell_i),
    .qual_map_o(qual_map_o), .age_o(age_o));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  bit m_q   [N];
  int m_dw  [N];
  int m_age [N];

  function automatic int magnitude(input logic [OW-1:0] v);
    int s;
    s = int'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  function automatic int removal_limit(input int q, input int d);
    return (d > q) ? d : q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      int  m;
      bit  inq, drop;
      m    = magnitude(ofs[i]);
      inq  = !alarm_i[i] && (m <= int'(qual_lim_i));
      drop = alarm_i[i] || (m > removal_limit(int'(qual_lim_i), int'(disq_lim_i)));
      if (!m_q[i]) begin
        if (!inq) m_dw[i] = 0;
        else if (m_dw[i] >= int'(dwell_i)) begin m_q[i] = 1; m_dw[i] = 0; m_age[i] = 0; end
        else m_dw[i]++;
      end else if (drop) begin
        m_q[i] = 0; m_dw[i] = 0; m_age[i] = 0;
      end else if (m_age[i] < AGEMAX) m_age[i]++;
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < N; i++) begin
      check("R2 status vs model", int'(qual_map_o[i]), int'(m_q[i]));
      check("R8 age vs model", int'(age_o[i*AW +: AW]), m_age[i]);
    end
  endtask

  // One clock: model advances on the edge, outputs compared at the falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_ref(input int i, input bit al, input int off);
    alarm_i[i] = al;
    ofs[i]     = OW'(off);
  endtask

  task automatic randomize_inputs();
    for (int i = 0; i < N; i++) begin
      int r, q;
      q = int'(qual_lim_i);
      r = $urandom_range(0, 99);
      alarm_i[i] = (r < 2);
      r = $urandom_range(0, 99);
      if (r < 85)      ofs[i] = OW'($urandom_range(0, 2 * q) - q);
      else if (r < 95) ofs[i] = OW'(q + 1 + $urandom_range(0, 250));
      else             ofs[i] = OW'(-(q + 1 + $urandom_range(0, 600)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < N; i++) begin
      set_ref(i, 1'b0, 0);
      m_q[i] = 0; m_dw[i] = 0; m_age[i] = 0;
    end
    qual_lim_i = 16'd100; disq_lim_i = 16'd200; dwell_i = 16'd3;
    repeat (3) @(negedge clk);
    // R1: reset state with in-range inputs applied
    check("R1 status after reset", int'(qual_map_o), 0);
    check("R1 age after reset", int'(age_o), 0);
    rst_n = 1'b1;

    // R2/R9: only ref0 clean; D=3 means rise on 4th clean cycle
    for (int i = 1; i < N; i++) set_ref(i, 1'b1, 0);
    repeat (3) cycle();
    check("R2 not before D+1 cycles", int'(qual_map_o[0]), 0);
    cycle();
    check("R2 rises after D+1 cycles", int'(qual_map_o[0]), 1);
    check("R9 bit position of ref0", int'(qual_map_o), 1);

    // R5: middle band keeps status, beyond removal limit drops it
    set_ref(0, 1'b0, 150);  repeat (3) cycle();
    set_ref(0, 1'b0, -200); repeat (2) cycle();
    check("R5 middle band holds", int'(qual_map_o[0]), 1);
    set_ref(0, 1'b0, 201); cycle();
    check("R5 beyond removal limit drops", int'(qual_map_o[0]), 0);

    // R3: one out-of-range cycle restarts the count
    set_ref(0, 1'b0, 0); repeat (3) cycle();
    set_ref(0, 1'b0, 101); cycle();
    set_ref(0, 1'b0, -100); repeat (3) cycle();
    check("R3 count restarted", int'(qual_map_o[0]), 0);
    cycle();
    check("R3 rise after full dwell", int'(qual_map_o[0]), 1);

    // R4 then R10
    set_ref(0, 1'b1, 0); cycle();
    check("R4 alarm drops", int'(qual_map_o[0]), 0);
    set_ref(0, 1'b0, 0); repeat (3) cycle();
    check("R10 no early requalify", int'(qual_map_o[0]), 0);
    cycle();
    check("R10 requalified", int'(qual_map_o[0]), 1);

    // R7: most negative code is far out of range; boundary -100 qualifies
    set_ref(1, 1'b0, -100);
    set_ref(2, 1'b0, -32768);
    repeat (4) cycle();
    check("R7 boundary negative qualifies", int'(qual_map_o[1]), 1);
    check("R7 most negative rejected", int'(qual_map_o[2]), 0);

    // R6: removal limit below entry limit is raised to it
    qual_lim_i = 16'd300; disq_lim_i = 16'd100;
    set_ref(1, 1'b0, 0);
    set_ref(0, 1'b0, 250); repeat (2) cycle();
    check("R6 effective limit holds", int'(qual_map_o[0]), 1);
    set_ref(0, 1'b0, -301); cycle();
    check("R6 beyond effective limit drops", int'(qual_map_o[0]), 0);

    // R8: hold ref1 long enough to saturate age
    repeat (AGEMAX + 20) cycle();
    check("R8 age saturates", int'(age_o[1*AW +: AW]), AGEMAX);

    // Random phase, dwell and limits varied
    for (int blk = 0; blk < 12; blk++) begin
      dwell_i    = DW'($urandom_range(0, 20));
      qual_lim_i = OW'($urandom_range(50, 400));
      disq_lim_i = OW'(int'(qual_lim_i) + $urandom_range(0, 300) - 40);
      for (int k = 0; k < 500; k++) begin
        randomize_inputs();
        cycle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule